// File: doc/BRIEF.md
# H-Bridge Commutation Sequencer

This block sequences the four switch enables of one H-bridge around a single motor winding. It turns on only diagonal transistor pairs, so winding current flows one way or the other, or not at all. Each commutation swaps the active pair, which reverses the winding current. Every swap passes through an interval with all four switches off. The length of that interval is set in clock cycles.

Commutation events come from one of two sources, picked by a mode input. In sensed mode every transition of a rotor-position input commutes the bridge, after the input has been synchronized. In open-loop mode an internal down-counter, reloaded from a 16-bit rate value, steps the bridge at a fixed rate with no position feedback. Dropping the enable input turns the bridge off. When enable returns, the sequence restarts from pair A.

Top module: `hbridge_commutator`

## Requirements
- R1: The gate outputs, written {gate_ul, gate_ur, gate_ll, gate_lr}, only ever take one of three values: 4'b0000 (off), 4'b1001 (pair A: upper-left with lower-right) or 4'b0110 (pair B: upper-right with lower-left).
- R2: The two switches of one side (gate_ul with gate_ll, gate_ur with gate_lr) are never on in the same cycle.
- R3: While rst_n is low, all gates are off. When enable is sampled low at a clock edge, all gates are off after that edge.
- R4: Once the bridge is off, the first edge that samples enable high turns on pair A.
- R5: A commutation event sampled at an edge while a pair is on turns all gates off for D cycles, with D = dead_len (a dead_len of 0 is treated as 1). The opposite pair is then turned on.
- R6: In sensed mode (mode_sel = 0), each transition of sensor_in in either direction is a commutation event. A change applied before edge e0 turns the gates off at edge e0+2.
- R7: In open-loop mode (mode_sel = 1), pair A stays on for rate_reload+1 cycles after it turns on. From then on a commutation event occurs every rate_reload+1 cycles, counted from the previous event.
- R8: A commutation event that arrives while the gates are off during the dead interval is ignored. The pair that follows is unchanged and no further swap occurs.
- R9: In sensed mode the rate timer causes no commutation. Pair A stays on indefinitely when no sensor transitions occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces all gates off |
| mode_sel | input | 1 | 0 = sensed commutation, 1 = open-loop timer |
| sensor_in | input | 1 | Asynchronous rotor-position input |
| rate_reload | input | RATE_W (16) | Open-loop period minus one, in cycles |
| dead_len | input | DEAD_W (8) | All-off interval length in cycles |
| gate_ul | output | 1 | Upper-left switch enable |
| gate_ur | output | 1 | Upper-right switch enable |
| gate_ll | output | 1 | Lower-left switch enable |
| gate_lr | output | 1 | Lower-right switch enable |

## Verification
The bench builds the block with its default widths: a 16-bit rate reload and an 8-bit dead length. Period and dead length are runtime inputs, so reloads of 2 to 5 cycles and dead lengths of 0 to 3 bring several full open-loop cycles into a few dozen clocks. The same short settings reach the zero-dead-length rule and the synchronizer latency. Sensor transitions are placed inside the dead interval to show that an event arriving then is dropped.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PAIRA = 2'd1,
        ST_PAIRB = 2'd2,
        ST_GAP   = 2'd3
    } hbc_state_e;
endpackage

// File: rtl/hbc_edge_sync.sv
module hbc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic toggle_o
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
        s_d.last   = s_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign toggle_o = s_q.stable ^ s_q.last;
endmodule

// File: rtl/hbc_rate_timer.sv
module hbc_rate_timer #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [RATE_W-1:0] reload,
    output logic              tick_o
);
    logic [RATE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || cnt_q == '0) cnt_d = reload;
        else                        cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = !restart && (cnt_q == '0);

    // R7
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/hbridge_commutator.sv
module hbridge_commutator #(
    parameter int RATE_W = 16,
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mode_sel,
    input  logic              sensor_in,
    input  logic [RATE_W-1:0] rate_reload,
    input  logic [DEAD_W-1:0] dead_len,
    output logic              gate_ul,
    output logic              gate_ur,
    output logic              gate_ll,
    output logic              gate_lr
);
    import hbc_pkg::*;

    localparam logic [DEAD_W-1:0] MIN_GAP = DEAD_W'(1);

    typedef struct packed {
        hbc_state_e        state;
        logic              go_b;
        logic [DEAD_W-1:0] gap_cnt;
    } seq_t;

    seq_t r_d, r_q;
    logic sens_evt, tmr_evt, step, tmr_restart;
    logic [DEAD_W-1:0] gap_len;

    hbc_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sensor_in),
        .toggle_o (sens_evt)
    );

    assign tmr_restart = !enable || !mode_sel || (r_q.state == ST_OFF);

    hbc_rate_timer #(.RATE_W(RATE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .reload  (rate_reload),
        .tick_o  (tmr_evt)
    );

    assign step    = mode_sel ? tmr_evt : sens_evt;
    assign gap_len = (dead_len == '0) ? MIN_GAP : dead_len;

    always_comb begin
        r_d = r_q;
        if (!enable) begin
            r_d.state   = ST_OFF;
            r_d.go_b    = 1'b0;
            r_d.gap_cnt = '0;
        end else begin
            unique case (r_q.state)
                ST_OFF:   r_d.state = ST_PAIRA;
                ST_PAIRA: if (step) begin
                    r_d.state   = ST_GAP;
                    r_d.go_b    = 1'b1;
                    r_d.gap_cnt = gap_len;
                end
                ST_PAIRB: if (step) begin
                    r_d.state   = ST_GAP;
                    r_d.go_b    = 1'b0;
                    r_d.gap_cnt = gap_len;
                end
                ST_GAP: begin
                    if (r_q.gap_cnt <= MIN_GAP)
                        r_d.state = r_q.go_b ? ST_PAIRB : ST_PAIRA;
                    else
                        r_d.gap_cnt = r_q.gap_cnt - 1'b1;
                end
                default: r_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_OFF, go_b: 1'b0, gap_cnt: '0};
        else        r_q <= r_d;
    end

    assign gate_ul = (r_q.state == ST_PAIRA);
    assign gate_lr = (r_q.state == ST_PAIRA);
    assign gate_ur = (r_q.state == ST_PAIRB);
    assign gate_ll = (r_q.state == ST_PAIRB);

    logic [3:0] gates;
    assign gates = {gate_ul, gate_ur, gate_ll, gate_lr};

    // R1
    legal_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gates == 4'b0000) || (gates == 4'b1001) || (gates == 4'b0110));
    // R2
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_ul && gate_ll) && !(gate_ur && gate_lr));
    // R5
    gap_a_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gates == 4'b1001) |=> (gates != 4'b0110));
    // R5
    gap_b_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gates == 4'b0110) |=> (gates != 4'b1001));
    // R3
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gates == 4'b0000));
    // R4
    start_pair_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_OFF && enable) |=> (gates == 4'b1001));
endmodule

// File: tb/hbridge_commutator_tb.sv
module hbridge_commutator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        mode_sel = 1'b1;
    logic        sensor_in = 1'b0;
    logic [15:0] rate_reload = 16'd3;
    logic [7:0]  dead_len = 8'd2;
    logic gate_ul, gate_ur, gate_ll, gate_lr;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [3:0] OFF = 4'b0000, PA = 4'b1001, PB = 4'b0110;

    always #5 clk = ~clk;

    hbridge_commutator u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_sel(mode_sel),
        .sensor_in(sensor_in), .rate_reload(rate_reload), .dead_len(dead_len),
        .gate_ul(gate_ul), .gate_ur(gate_ur), .gate_ll(gate_ll), .gate_lr(gate_lr)
    );

    // {reload, dead, cycles after enabling edge, expected gates}
    localparam int NV = 22;
    localparam logic [35:0] VEC [NV] = '{
        {16'd3, 8'd2, 8'd0,  PA},  {16'd3, 8'd2, 8'd3,  PA},
        {16'd3, 8'd2, 8'd4,  OFF}, {16'd3, 8'd2, 8'd5,  OFF},
        {16'd3, 8'd2, 8'd6,  PB},  {16'd3, 8'd2, 8'd7,  PB},
        {16'd3, 8'd2, 8'd8,  OFF}, {16'd3, 8'd2, 8'd10, PA},
        {16'd5, 8'd1, 8'd5,  PA},  {16'd5, 8'd1, 8'd6,  OFF},
        {16'd5, 8'd1, 8'd7,  PB},  {16'd5, 8'd1, 8'd11, PB},
        {16'd5, 8'd1, 8'd12, OFF}, {16'd5, 8'd1, 8'd13, PA},
        {16'd2, 8'd0, 8'd2,  PA},  {16'd2, 8'd0, 8'd3,  OFF},
        {16'd2, 8'd0, 8'd4,  PB},  {16'd2, 8'd0, 8'd5,  PB},
        {16'd2, 8'd0, 8'd6,  OFF}, {16'd2, 8'd0, 8'd7,  PA},
        {16'd0, 8'd1, 8'd0,  PA},  {16'd0, 8'd1, 8'd2,  PB}
    };

    function automatic logic [3:0] gates();
        return {gate_ul, gate_ur, gate_ll, gate_lr};
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        n_chk++;
        if (gates() !== exp) begin
            n_bad++;
            $display("FAIL %s: gates=%b expected=%b", tag, gates(), exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: gates=%b expected=completion", gates());
        finish_run();
    end

    initial begin
        edges(2);
        check("R3 reset off", OFF);
        rst_n = 1'b1;
        edges(1);
        check("R3 disabled off", OFF);

        // R7 R5 open-loop vectors, each from a fresh start
        for (int i = 0; i < NV; i++) begin
            enable = 1'b0;
            mode_sel = 1'b1;
            rate_reload = VEC[i][35:20];
            dead_len = VEC[i][19:12];
            edges(2);
            enable = 1'b1;
            edges(int'(VEC[i][11:4]) + 1);
            check($sformatf("R7/R5 vec%0d", i), VEC[i][3:0]);
        end

        // R6 R8 sensed mode
        enable = 1'b0;
        mode_sel = 1'b0;
        dead_len = 8'd3;
        edges(3);
        enable = 1'b1;
        edges(1);
        check("R4 start pair A", PA);
        sensor_in = 1'b1;
        edges(1); check("R6 e0 still A", PA);
        edges(1); check("R6 e1 still A", PA);
        edges(1); check("R6 e2 off", OFF);
        sensor_in = 1'b0;              // lands during the dead interval
        edges(2); check("R5 e4 still off", OFF);
        edges(1); check("R5 e5 pair B", PB);
        edges(2); check("R8 late event ignored", PB);
        edges(3); check("R8 still B", PB);
        sensor_in = 1'b1;
        edges(3); check("R6 B to off", OFF);
        edges(3); check("R6 back to A", PA);

        // R9 timer idle in sensed mode
        rate_reload = 16'd2;
        dead_len = 8'd1;
        edges(40);
        check("R9 no timer step", PA);

        // R3 R4 disable and restart from A while B is on
        sensor_in = 1'b0;
        edges(4);
        check("R6 to B", PB);
        enable = 1'b0;
        edges(1);
        check("R3 disable off", OFF);
        enable = 1'b1;
        edges(1);
        check("R4 restart A", PA);

        finish_run();
    end
endmodule